// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a register-driven I2C bus master that software steers one byte at a time. A processor uses its control word to request START, repeated START and STOP conditions. It sends address and data bytes by writing the data word, and it pulls received bytes in by reading that same word. After each byte the block sets a completion flag, and it reports whether the far end acknowledged. Open-drain SDA and SCL are presented as an output-enable (drive low) and an input sense per line.

Bus timing is set outside the block. A `scl_tick` pulse advances the bit engine by one quarter of an SCL period. The divider word is kept only so that software can read it back. While receiving, each read of the data word hands over the byte that last arrived and starts the next one. The first read after switching direction is therefore a throwaway. A control bit selects whether the next received byte is answered with ACK or NACK.

Register words are selected by `reg_sel`: 0 own address, 1 divider, 2 control, 3 status, 4 data. Only bits 31:24 carry content.

Top module: `i2c_byte_master`

## Requirements
- R1: Register content sits in bits 31:24 of every 32-bit word. Bits 23:0 always read as zero, and their written value is ignored.
- R2: The own-address word keeps written bits 7:1 and reads bit 0 as zero. The divider word reads back the full byte written to it.
- R3: With control bit 7 (enable) set, setting control bit 5 (start) while idle drives SDA low and then SCL low while SCL is still high. SCL is then held low. Status bit 5 (busy) reads 1.
- R4: With control bit 4 (transmit) set, a write to the data word sends that byte MSB first. SDA does not change while SCL is released. The address byte is the 7-bit address in bits 7:1 with bit 0 set to 1 for a read.
- R5: Status bit 1 (done) sets at the end of each byte's acknowledge slot. It stays set until status is written with bit 1 = 0. Writing bit 1 = 1 leaves it set.
- R6: Status bit 0 reads 0 when the far end acknowledged the last transmitted byte and 1 when it answered NACK, for example on an unknown address.
- R7: Setting control bit 2 (repeated start) while master produces a new START without a STOP. Busy stays 1, and the next address byte goes out.
- R8: With transmit cleared, a read of the data word returns the last received byte and starts receiving the next. The first read after switching is a dummy.
- R9: Control bit 3 (no-ack) set makes the block answer the next received byte with NACK. When it is clear, the block answers with ACK.
- R10: Clearing start while master produces a STOP (SDA rises while SCL is high). Afterwards both lines are released and busy reads 0.
- R11: Clearing enable returns the engine to idle, releases both lines and clears busy and done.
- R12: After reset all words read zero and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_tick | input | 1 | Quarter-SCL-period enable pulse |
| reg_sel | input | 3 | Register word select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (acts on the data word) |
| reg_wdata | input | 32 | Write data, content in bits 31:24 |
| reg_rdata | output | 32 | Read data, content in bits 31:24 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Sensed SCL level |

## Verification
A behavioural slave answers one address and logs written bytes. In read mode it returns bytes that depend on the last written pointer. A pure write transaction shows MSB-first shifting and ACK reporting, and distinct byte values show that the bit order is not reversed. An unknown address separates the ACK and NACK status paths. A write-then-read with a repeated START checks the dummy-read offset, because each returned byte must equal the pattern for the previous slot. The slave's count of master ACKs and NACKs shows that no-ack takes effect only on the last byte. A final disable in the middle of a transfer shows that busy and done clear and both lines are released.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_tick,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sda_oe,
  input  logic        sda_in,
  output logic        scl_oe,
  input  logic        scl_in
);
  typedef enum logic [2:0] {S_IDLE, S_RSTART, S_HOLD, S_BYTE, S_STOP} st_t;

  st_t        st;
  logic [7:0] own_q, div_q, shreg;
  logic       en, sta, tx, noack, rsta;
  logic       done, busy, rxak, go;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic       sda_drv, scl_drv, sda_q, scl_q;

  wire [7:0] wb     = reg_wdata[31:24];
  wire       wr_own = reg_wr && reg_sel == 3'd0;
  wire       wr_div = reg_wr && reg_sel == 3'd1;
  wire       wr_ctl = reg_wr && reg_sel == 3'd2;
  wire       wr_st  = reg_wr && reg_sel == 3'd3;
  wire       wr_dat = reg_wr && reg_sel == 3'd4;
  wire       rd_dat = reg_rd && reg_sel == 3'd4;
  wire       trig   = (wr_dat && tx) || (rd_dat && !tx);
  wire       bus_start = scl_q && scl_in && sda_q && !sda_in;
  wire       bus_stop  = scl_q && scl_in && !sda_q && sda_in;

  logic unused_low;
  assign unused_low = ^reg_wdata[23:0];

  assign sda_oe = sda_drv;
  assign scl_oe = scl_drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; own_q <= '0; div_q <= '0; shreg <= '0;
      en <= 1'b0; sta <= 1'b0; tx <= 1'b0; noack <= 1'b0; rsta <= 1'b0;
      done <= 1'b0; busy <= 1'b0; rxak <= 1'b0; go <= 1'b0;
      ph <= '0; bitn <= '0; sda_drv <= 1'b0; scl_drv <= 1'b0;
      sda_q <= 1'b1; scl_q <= 1'b1;
    end else begin
      sda_q <= sda_in;
      scl_q <= scl_in;
      if (wr_own) own_q <= {wb[7:1], 1'b0};
      if (wr_div) div_q <= wb;
      if (wr_ctl) {en, sta, tx, noack, rsta} <= {wb[7], wb[5], wb[4], wb[3], wb[2]};
      if (wr_dat && tx && st != S_BYTE) shreg <= wb;
      if (trig) go <= 1'b1;
      if (wr_st && !wb[1]) done <= 1'b0;
      if (bus_start) busy <= 1'b1;
      else if (bus_stop) busy <= 1'b0;

      if (!en) begin
        st <= S_IDLE; sda_drv <= 1'b0; scl_drv <= 1'b0;
        done <= 1'b0; busy <= 1'b0; go <= 1'b0; ph <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            go <= 1'b0;
            if (sta) begin st <= S_RSTART; ph <= 2'd1; end
          end
          S_RSTART: if (scl_tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_drv <= 1'b0;
              2'd1: scl_drv <= 1'b0;
              2'd2: sda_drv <= 1'b1;
              2'd3: begin scl_drv <= 1'b1; st <= S_HOLD; end
            endcase
          end
          S_HOLD: begin
            if (!sta) begin st <= S_STOP; ph <= '0; end
            else if (rsta) begin st <= S_RSTART; ph <= '0; rsta <= 1'b0; end
            else if (go) begin go <= 1'b0; st <= S_BYTE; ph <= '0; bitn <= '0; end
          end
          S_BYTE: if (scl_tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_drv <= (bitn == 4'd8) ? (!tx && !noack) : (tx && !shreg[7]);
              2'd1: scl_drv <= 1'b0;
              2'd2: if (bitn == 4'd8) rxak <= sda_in;
                    else shreg <= {shreg[6:0], sda_in};
              2'd3: begin
                scl_drv <= 1'b1;
                bitn <= bitn + 4'd1;
                if (bitn == 4'd8) begin done <= 1'b1; st <= S_HOLD; end
              end
            endcase
          end
          S_STOP: if (scl_tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_drv <= 1'b1;
              2'd1: scl_drv <= 1'b0;
              2'd2: sda_drv <= 1'b0;
              2'd3: st <= S_IDLE;
            endcase
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic [7:0] rbyte;
  always_comb begin
    case (reg_sel)
      3'd0:    rbyte = own_q;
      3'd1:    rbyte = div_q;
      3'd2:    rbyte = {en, 1'b0, sta, tx, noack, rsta, 2'b00};
      3'd3:    rbyte = {2'b00, busy, 3'b000, done, rxak};
      3'd4:    rbyte = shreg;
      default: rbyte = 8'h00;
    endcase
    reg_rdata = {rbyte, 24'h000000};
  end

  // R11
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_drv && !scl_drv && !done && !busy));
  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && en && !(wr_st && !wb[1])) |=> done);
  // R6
  rxak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_BYTE) |=> $stable(rxak));
  // R4
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_BYTE && !scl_drv) |=> $stable(sda_drv));
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_STOP && scl_tick && ph == 2'd3) |=> (!sda_drv && !scl_drv));
endmodule

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  localparam logic [6:0] SLV = 7'h52;
  logic clk = 1'b0, rst_n = 1'b0, scl_tick = 1'b0;
  logic [2:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sda_oe, scl_oe, sda_line, scl_line;
  int total = 0, bad = 0;

  logic s_drv = 1'b0, s_act = 1'b0, s_first = 1'b0, s_rd = 1'b0, s_after = 1'b0, s_nk = 1'b0;
  logic sclv = 1'b1, sdav = 1'b1;
  int s_cnt = 0, s_wn = 0, s_widx = 0, s_rk = 0, s_macks = 0, s_mnacks = 0;
  logic [7:0] s_sh = '0, s_tx = '0, ptr = '0;
  logic [7:0] s_log [0:7];

  assign sda_line = !(sda_oe || s_drv);
  assign scl_line = !scl_oe;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .scl_tick(scl_tick), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sda_oe(sda_oe), .sda_in(sda_line), .scl_oe(scl_oe), .scl_in(scl_line));

  always #2.5 clk = ~clk;

  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    scl_tick = (tcnt == 0);
  end

  function automatic logic [7:0] pat(input logic [7:0] k);
    return 8'h96 ^ (k * 8'd29);
  endfunction

  always @(scl_line or sda_line) begin
    if (sclv && scl_line && sdav && !sda_line) begin
      s_act = 1'b1; s_first = 1'b1; s_cnt = 0; s_drv = 1'b0; s_after = 1'b0;
      s_rk = 0; s_widx = 0; s_nk = 1'b0; s_rd = 1'b0;
    end else if (sclv && scl_line && !sdav && sda_line) begin
      s_act = 1'b0; s_drv = 1'b0;
    end else if (!sclv && scl_line && s_act) begin
      if (s_cnt < 8) begin s_sh = {s_sh[6:0], sda_line}; s_cnt++; end
      else begin
        if (s_rd && !s_first) begin
          s_nk = sda_line;
          if (sda_line) s_mnacks++; else s_macks++;
        end
        s_cnt = 0; s_after = 1'b1;
      end
    end else if (sclv && !scl_line && s_act) begin
      if (s_cnt == 8) begin
        if (s_first) begin
          if (s_sh[7:1] == SLV) begin s_drv = 1'b1; s_rd = s_sh[0]; end
          else begin s_act = 1'b0; s_drv = 1'b0; end
        end else if (!s_rd) begin
          if (s_widx == 0) ptr = s_sh;
          s_widx++;
          if (s_wn < 8) s_log[s_wn] = s_sh;
          s_wn++; s_drv = 1'b1;
        end else s_drv = 1'b0;
      end else if (s_cnt == 0) begin
        if (s_after) begin
          s_after = 1'b0;
          if (s_rd && (s_first || !s_nk)) begin
            s_tx = pat(ptr + s_rk[7:0]); s_rk++; s_drv = ~s_tx[7];
          end else s_drv = 1'b0;
          s_first = 1'b0;
        end
      end else if (s_rd && !s_first) s_drv = ~s_tx[7 - s_cnt];
    end
    sclv = scl_line; sdav = sda_line;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] b);
    @(negedge clk);
    reg_sel = s; reg_wdata = {b, 24'h5AC3E1}; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] b, output logic [23:0] lo);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1;
    b = reg_rdata[31:24]; lo = reg_rdata[23:0];
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_done(input string req, output logic [7:0] st);
    logic [23:0] lo;
    st = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, st, lo);
      if (st[1]) break;
    end
    chk(req, {31'd0, st[1]}, 32'd1);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] st;
    logic [23:0] lo;
    st = 8'hFF;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, st, lo);
      if (!st[5]) break;
    end
    repeat (20) @(negedge clk);
    chk(req, {st[5], sda_oe, scl_oe}, 32'd0);
  endtask

  task automatic t_reset;
    logic [7:0] b; logic [23:0] lo;
    rd(3'd2, b, lo); chk("R12 ctrl", b, 0);
    rd(3'd3, b, lo); chk("R12 status", b, 0);
    rd(3'd4, b, lo); chk("R12 data", b, 0);
    chk("R12 lines", {sda_oe, scl_oe}, 0);
  endtask

  task automatic t_regs;
    logic [7:0] b; logic [23:0] lo;
    wr(3'd0, 8'hA5);
    rd(3'd0, b, lo); chk("R2 own", b, 8'hA4); chk("R1 low bits", lo, 0);
    wr(3'd1, 8'h3B);
    rd(3'd1, b, lo); chk("R2 div", b, 8'h3B);
  endtask

  task automatic t_write;
    logic [7:0] st, b; logic [23:0] lo;
    s_wn = 0;
    wr(3'd2, 8'h80);
    wr(3'd2, 8'hB0);
    wr(3'd4, {SLV, 1'b0});
    wait_done("R5 addr done", st);
    chk("R6 addr ack", st[0], 0);
    chk("R3 busy", st[5], 1);
    chk("R3 scl held", scl_oe, 1);
    wr(3'd3, 8'h02);
    rd(3'd3, b, lo); chk("R5 write1 keeps", b[1], 1);
    wr(3'd3, 8'h00);
    rd(3'd3, b, lo); chk("R5 write0 clears", b[1], 0);
    wr(3'd4, 8'h10); wait_done("R5 byte1", st); wr(3'd3, 8'h00);
    wr(3'd4, 8'hE7); wait_done("R5 byte2", st); wr(3'd3, 8'h00);
    chk("R6 data ack", st[0], 0);
    wr(3'd2, 8'h90);
    wait_idle("R10 stop");
    chk("R4 count", s_wn, 2);
    chk("R4 byte0", s_log[0], 8'h10);
    chk("R4 byte1", s_log[1], 8'hE7);
  endtask

  task automatic t_nack;
    logic [7:0] st;
    wr(3'd2, 8'hB0);
    wr(3'd4, {7'h11, 1'b0});
    wait_done("R5 nack done", st); wr(3'd3, 8'h00);
    chk("R6 nack", st[0], 1);
    wr(3'd2, 8'h90);
    wait_idle("R10 stop after nack");
  endtask

  task automatic t_read;
    logic [7:0] st, b; logic [23:0] lo;
    s_macks = 0; s_mnacks = 0;
    wr(3'd2, 8'hB0);
    wr(3'd4, {SLV, 1'b0}); wait_done("R5 w addr", st); wr(3'd3, 8'h00);
    wr(3'd4, 8'h05); wait_done("R5 ptr", st); wr(3'd3, 8'h00);
    wr(3'd2, 8'hB4);
    wr(3'd4, {SLV, 1'b1}); wait_done("R7 r addr", st); wr(3'd3, 8'h00);
    chk("R7 ack after rstart", st[0], 0);
    chk("R7 busy held", st[5], 1);
    wr(3'd2, 8'hA0);
    rd(3'd4, b, lo); wait_done("R8 dummy", st); wr(3'd3, 8'h00);
    rd(3'd4, b, lo); chk("R8 byte0", b, pat(8'h05));
    wait_done("R8 b1", st); wr(3'd3, 8'h00);
    wr(3'd2, 8'hA8);
    rd(3'd4, b, lo); chk("R8 byte1", b, pat(8'h06));
    wait_done("R8 b2", st); wr(3'd3, 8'h00);
    wr(3'd2, 8'h80);
    wait_idle("R10 stop after read");
    rd(3'd4, b, lo); chk("R8 byte2", b, pat(8'h07));
    chk("R9 acks", s_macks, 2);
    chk("R9 nacks", s_mnacks, 1);
  endtask

  task automatic t_disable;
    logic [7:0] st, b; logic [23:0] lo;
    wr(3'd2, 8'hB0);
    wr(3'd4, {SLV, 1'b0}); wait_done("R11 pre", st);
    wr(3'd2, 8'h00);
    repeat (2) @(negedge clk);
    rd(3'd3, b, lo); chk("R11 status", b, 0);
    chk("R11 lines", {sda_oe, scl_oe}, 0);
  endtask

  initial begin
    #750000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_write();
    t_nack();
    t_read();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule